// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block carries out the register bookkeeping a 32-bit core needs at the moment it takes one of three synchronous exceptions: a software trap, a data address error, or an illegal instruction. The core raises one or more single-cycle request strobes. In the same cycle it presents the current PC, the PC of the following instruction, the live status register, the vector base, the 8-bit trap immediate, the faulting virtual address and a flag that marks the access as a write.

The block picks one cause by fixed priority. On the next clock edge it loads every affected state register together: saved PC, saved status, event code, trap code and fault address. On that same edge it presents the new status word and a one-cycle redirect pulse carrying the handler address. Decode, the pipeline and interrupts are handled elsewhere.

Control is a two-state machine. `ST_IDLE` waits for a request. Transition `T_ENTER` (any request while idle) goes to `ST_REDIRECT`, where the redirect pulse is driven. From `ST_REDIRECT`, transition `T_CHAIN` (a new request) stays in `ST_REDIRECT` and reloads the registers. Transition `T_DONE` (no request) returns to `ST_IDLE`.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, saved_pc, saved_sr, event_code, trap_code, fault_addr, new_sr and redirect_pc are all zero, and redirect_vld is low.
- R2: On a software trap, saved_pc takes next_pc, saved_sr takes cur_sr, and event_code becomes 0x160.
- R3: On a software trap, trap_code equals trap_imm shifted left by two, so the immediate occupies bits 9..2. Bits 31..10 and 1..0 of trap_code are always zero.
- R4: On an address error, fault_addr takes the full 32-bit fault_va, saved_pc takes cur_pc, and saved_sr takes cur_sr.
- R5: An address error with fault_is_write=0 sets event_code to 0x0E0. With fault_is_write=1 it sets event_code to 0x100.
- R6: On an illegal instruction, event_code becomes the parameter value (default 0x180), saved_pc takes cur_pc, and saved_sr takes cur_sr.
- R7: For every accepted exception, new_sr equals cur_sr with bits 28, 29 and 30 forced to 1. All other bits are copied unchanged.
- R8: The edge that samples a request drives redirect_vld high for exactly one cycle, with redirect_pc = vbr + 0x100. A request in the redirect cycle keeps redirect_vld high for one more cycle and reloads the registers.
- R9: When requests coincide, the address error wins over the illegal instruction, and the illegal instruction wins over the trap. Only the winner's effects are recorded.
- R10: In a cycle with no request, every output register holds its value and redirect_vld stays low once the redirect cycle has ended.
- R11: fault_addr changes only on an accepted address error. trap_code changes only on an accepted trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Software trap strobe |
| addr_err_req | input | 1 | Data address error strobe |
| illegal_req | input | 1 | Illegal instruction strobe |
| cur_pc | input | 32 | PC of the excepting instruction |
| next_pc | input | 32 | PC of the following instruction |
| cur_sr | input | 32 | Status register in force |
| vbr | input | 32 | Vector base |
| trap_imm | input | 8 | Trap immediate |
| fault_va | input | 32 | Faulting virtual address |
| fault_is_write | input | 1 | 1 = faulting access was a write |
| saved_pc | output | 32 | Saved PC register |
| saved_sr | output | 32 | Saved status register |
| event_code | output | 12 | Exception event code register |
| trap_code | output | 32 | Trap code register |
| fault_addr | output | 32 | Fault address register |
| new_sr | output | 32 | Status word for the handler |
| redirect_vld | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Handler address |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the priority arbitration among coincident causes. The bench strobes all three requests together, and then only illegal plus trap. It judges the result by checking that the event code, saved PC and fault address belong to the winner, and that the trap code keeps its earlier value.

The second pair is the redirect cycle and a new request arriving during it. The bench raises requests on two consecutive edges. It checks that redirect_vld stays high across both cycles, that the second request's values replace the first's, and that the pulse drops one cycle after the last request.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    // Request vector index: lower index = higher priority
    localparam int SRC_ADDR = 0;
    localparam int SRC_ILL  = 1;
    localparam int SRC_TRAP = 2;
    localparam int N_SRC    = 3;

    typedef enum logic [1:0] {
        CZ_NONE  = 2'd0,
        CZ_ADDR  = 2'd1,
        CZ_ILL   = 2'd2,
        CZ_TRAP  = 2'd3
    } cause_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_REDIRECT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/exc_src_arbiter.sv
module exc_src_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // taken[i] is set when a higher-priority source (index < i) is requesting
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]       = req[i] & ~taken[i];
        assign taken[i + 1] = taken[i] | req[i];
    end

    assign any = taken[N];

endmodule

// File: rtl/exc_frame_builder.sv
module exc_frame_builder
    import exc_seq_pkg::*;
#(
    parameter int                 XLEN      = 32,
    parameter int                 EXP_W     = 12,
    parameter int                 IMM_W     = 8,
    parameter int                 BL_BIT    = 28,
    parameter int                 RB_BIT    = 29,
    parameter int                 MD_BIT    = 30,
    parameter logic [EXP_W-1:0]   CODE_TRAP = 'h160,
    parameter logic [EXP_W-1:0]   CODE_RD   = 'h0E0,
    parameter logic [EXP_W-1:0]   CODE_WR   = 'h100,
    parameter logic [EXP_W-1:0]   CODE_ILL  = 'h180,
    parameter logic [XLEN-1:0]    VEC_OFF   = 'h100
) (
    input  cause_e            cause,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   cur_sr,
    input  logic [XLEN-1:0]   vbr,
    input  logic [IMM_W-1:0]  trap_imm,
    input  logic [XLEN-1:0]   fault_va,
    input  logic              fault_is_write,
    output logic [XLEN-1:0]   spc_d,
    output logic [XLEN-1:0]   ssr_d,
    output logic [EXP_W-1:0]  expevt_d,
    output logic [XLEN-1:0]   tra_d,
    output logic [XLEN-1:0]   tea_d,
    output logic [XLEN-1:0]   sr_d,
    output logic [XLEN-1:0]   target_d,
    output logic              upd_tra,
    output logic              upd_tea
);
    localparam int TRA_SHIFT = 2;
    localparam logic [XLEN-1:0] BLOCK_MASK =
        (XLEN'(1) << BL_BIT) | (XLEN'(1) << RB_BIT) | (XLEN'(1) << MD_BIT);

    // Fields that do not depend on which cause won
    always_comb begin
        ssr_d    = cur_sr;
        sr_d     = cur_sr | BLOCK_MASK;
        target_d = vbr + VEC_OFF;
        tra_d    = XLEN'(trap_imm) << TRA_SHIFT;
        tea_d    = fault_va;
    end

    // Cause-dependent selection
    always_comb begin
        spc_d    = cur_pc;
        expevt_d = '0;
        upd_tra  = 1'b0;
        upd_tea  = 1'b0;
        unique case (cause)
            CZ_TRAP: begin
                spc_d    = next_pc;
                expevt_d = CODE_TRAP;
                upd_tra  = 1'b1;
            end
            CZ_ADDR: begin
                spc_d    = cur_pc;
                expevt_d = fault_is_write ? CODE_WR : CODE_RD;
                upd_tea  = 1'b1;
            end
            CZ_ILL: begin
                spc_d    = cur_pc;
                expevt_d = CODE_ILL;
            end
            CZ_NONE: begin
                spc_d    = cur_pc;
                expevt_d = '0;
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int                XLEN     = 32,
    parameter int                EXP_W    = 12,
    parameter int                IMM_W    = 8,
    parameter logic [EXP_W-1:0]  ILL_CODE = 'h180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              addr_err_req,
    input  logic              illegal_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   cur_sr,
    input  logic [XLEN-1:0]   vbr,
    input  logic [IMM_W-1:0]  trap_imm,
    input  logic [XLEN-1:0]   fault_va,
    input  logic              fault_is_write,
    output logic [XLEN-1:0]   saved_pc,
    output logic [XLEN-1:0]   saved_sr,
    output logic [EXP_W-1:0]  event_code,
    output logic [XLEN-1:0]   trap_code,
    output logic [XLEN-1:0]   fault_addr,
    output logic [XLEN-1:0]   new_sr,
    output logic              redirect_vld,
    output logic [XLEN-1:0]   redirect_pc
);
    localparam int BL_BIT = 28;
    localparam int RB_BIT = 29;
    localparam int MD_BIT = 30;
    localparam int TRA_HI = IMM_W + 2;

    // ---------------- arbitration ----------------
    logic [N_SRC-1:0] req_vec;
    logic [N_SRC-1:0] gnt;
    logic             any_req;
    cause_e           cause;

    assign req_vec[SRC_ADDR] = addr_err_req;
    assign req_vec[SRC_ILL]  = illegal_req;
    assign req_vec[SRC_TRAP] = trap_req;

    exc_src_arbiter #(.N(N_SRC)) u_arb (
        .req (req_vec),
        .gnt (gnt),
        .any (any_req)
    );

    always_comb begin
        cause = CZ_NONE;
        if (gnt[SRC_ADDR])      cause = CZ_ADDR;
        else if (gnt[SRC_ILL])  cause = CZ_ILL;
        else if (gnt[SRC_TRAP]) cause = CZ_TRAP;
    end

    // ---------------- frame computation ----------------
    logic [XLEN-1:0]  spc_d, ssr_d, tra_d, tea_d, sr_d, target_d;
    logic [EXP_W-1:0] expevt_d;
    logic             upd_tra, upd_tea;

    exc_frame_builder #(
        .XLEN     (XLEN),
        .EXP_W    (EXP_W),
        .IMM_W    (IMM_W),
        .BL_BIT   (BL_BIT),
        .RB_BIT   (RB_BIT),
        .MD_BIT   (MD_BIT),
        .CODE_ILL (ILL_CODE)
    ) u_frame (
        .cause          (cause),
        .cur_pc         (cur_pc),
        .next_pc        (next_pc),
        .cur_sr         (cur_sr),
        .vbr            (vbr),
        .trap_imm       (trap_imm),
        .fault_va       (fault_va),
        .fault_is_write (fault_is_write),
        .spc_d          (spc_d),
        .ssr_d          (ssr_d),
        .expevt_d       (expevt_d),
        .tra_d          (tra_d),
        .tea_d          (tea_d),
        .sr_d           (sr_d),
        .target_d       (target_d),
        .upd_tra        (upd_tra),
        .upd_tea        (upd_tea)
    );

    // ---------------- state machine ----------------
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = any_req ? ST_REDIRECT : ST_IDLE;  // T_ENTER
            ST_REDIRECT: state_d = any_req ? ST_REDIRECT : ST_IDLE;  // T_CHAIN / T_DONE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- output registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_pc    <= '0;
            saved_sr    <= '0;
            event_code  <= '0;
            trap_code   <= '0;
            fault_addr  <= '0;
            new_sr      <= '0;
            redirect_pc <= '0;
        end else if (any_req) begin
            saved_pc    <= spc_d;
            saved_sr    <= ssr_d;
            event_code  <= expevt_d;
            new_sr      <= sr_d;
            redirect_pc <= target_d;
            if (upd_tra) trap_code  <= tra_d;
            if (upd_tea) fault_addr <= tea_d;
        end
    end

    assign redirect_vld = (state_q == ST_REDIRECT);

    // ---------------- assertions ----------------
    p_tra_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_code[XLEN-1:TRA_HI] == '0) && (trap_code[1:0] == 2'b00));

    p_block_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> (new_sr[BL_BIT] && new_sr[RB_BIT] && new_sr[MD_BIT]));

    p_redirect_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> redirect_vld);

    p_redirect_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> !redirect_vld);

    p_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> (redirect_pc == $past(vbr) + XLEN'('h100)));

    p_addr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_req |=> (fault_addr == $past(fault_va)));

    p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (any_req == (|req_vec)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> ($stable(saved_pc) && $stable(saved_sr) &&
                      $stable(event_code) && $stable(new_sr)));

    p_tea_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_err_req |=> $stable(fault_addr));

    p_tra_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt[SRC_TRAP] |=> $stable(trap_code));

endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 0, addr_err_req = 0, illegal_req = 0;
    logic [31:0] cur_pc = 0, next_pc = 0, cur_sr = 0, vbr = 0, fault_va = 0;
    logic [7:0]  trap_imm = 0;
    logic        fault_is_write = 0;
    logic [31:0] saved_pc, saved_sr, trap_code, fault_addr, new_sr, redirect_pc;
    logic [11:0] event_code;
    logic        redirect_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .trap_req(trap_req), .addr_err_req(addr_err_req), .illegal_req(illegal_req),
        .cur_pc(cur_pc), .next_pc(next_pc), .cur_sr(cur_sr), .vbr(vbr),
        .trap_imm(trap_imm), .fault_va(fault_va), .fault_is_write(fault_is_write),
        .saved_pc(saved_pc), .saved_sr(saved_sr), .event_code(event_code),
        .trap_code(trap_code), .fault_addr(fault_addr), .new_sr(new_sr),
        .redirect_vld(redirect_vld), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one request cycle at the falling edge, sample just after the rising edge
    task automatic fire(input bit t, input bit a, input bit il,
                        input logic [31:0] pc, input logic [31:0] sr,
                        input logic [31:0] vb, input logic [7:0] imm,
                        input logic [31:0] va, input bit wr);
        @(negedge clk);
        trap_req = t; addr_err_req = a; illegal_req = il;
        cur_pc = pc; next_pc = pc + 32'd2; cur_sr = sr; vbr = vb;
        trap_imm = imm; fault_va = va; fault_is_write = wr;
        @(posedge clk); #1;
    endtask

    task automatic quiet();
        @(negedge clk);
        trap_req = 0; addr_err_req = 0; illegal_req = 0;
        cur_pc = 32'h5555_0000; next_pc = 32'h5555_0002; cur_sr = 32'h0;
        vbr = 32'h1111_0000; trap_imm = 8'hFF; fault_va = 32'h9999_9999;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R1", "saved_pc", saved_pc, 0);
        chk("R1", "saved_sr", saved_sr, 0);
        chk("R1", "event_code", {20'd0, event_code}, 0);
        chk("R1", "trap_code", trap_code, 0);
        chk("R1", "fault_addr", fault_addr, 0);
        chk("R1", "new_sr", new_sr, 0);
        chk("R1", "redirect_pc", redirect_pc, 0);
        chk("R1", "redirect_vld", {31'd0, redirect_vld}, 0);
    endtask

    task automatic t_trap();
        fire(1, 0, 0, 32'h0000_1000, 32'h0000_00F1, 32'h8000_0000, 8'hAB, 32'hCAFE_0000, 0);
        chk("R2", "saved_pc", saved_pc, 32'h0000_1002);
        chk("R2", "saved_sr", saved_sr, 32'h0000_00F1);
        chk("R2", "event_code", {20'd0, event_code}, 32'h160);
        chk("R3", "trap_code", trap_code, 32'h0000_02AC);
        chk("R7", "new_sr", new_sr, 32'h7000_00F1);
        chk("R8", "redirect_vld", {31'd0, redirect_vld}, 1);
        chk("R8", "redirect_pc", redirect_pc, 32'h8000_0100);
        chk("R11", "fault_addr after trap", fault_addr, 0);
        quiet();
        chk("R8", "redirect_vld drop", {31'd0, redirect_vld}, 0);
    endtask

    task automatic t_trap_max_imm();
        fire(1, 0, 0, 32'h0000_2000, 32'h0, 32'h0, 8'hFF, 32'h0, 0);
        chk("R3", "trap_code max imm", trap_code, 32'h0000_03FC);
        quiet();
    endtask

    task automatic t_addr_read();
        fire(0, 1, 0, 32'h0000_3000, 32'h8F00_0001, 32'h0000_4000, 8'h12, 32'hDEAD_BEEF, 0);
        chk("R4", "fault_addr", fault_addr, 32'hDEAD_BEEF);
        chk("R4", "saved_pc", saved_pc, 32'h0000_3000);
        chk("R4", "saved_sr", saved_sr, 32'h8F00_0001);
        chk("R5", "event_code read", {20'd0, event_code}, 32'h0E0);
        chk("R7", "new_sr", new_sr, 32'hFF00_0001);
        chk("R11", "trap_code held", trap_code, 32'h0000_03FC);
        chk("R8", "redirect_pc", redirect_pc, 32'h0000_4100);
        quiet();
    endtask

    task automatic t_addr_write();
        fire(0, 1, 0, 32'h0000_3010, 32'hFFFF_FFFF, 32'hFFFF_FF00, 8'h00, 32'h1234_5678, 1);
        chk("R5", "event_code write", {20'd0, event_code}, 32'h100);
        chk("R4", "fault_addr", fault_addr, 32'h1234_5678);
        chk("R7", "new_sr all ones", new_sr, 32'hFFFF_FFFF);
        chk("R8", "redirect_pc wrap", redirect_pc, 32'h0000_0000);
        quiet();
    endtask

    task automatic t_illegal();
        fire(0, 0, 1, 32'h0000_5000, 32'h0000_0002, 32'h0001_0000, 8'h33, 32'hAAAA_AAAA, 1);
        chk("R6", "event_code", {20'd0, event_code}, 32'h180);
        chk("R6", "saved_pc", saved_pc, 32'h0000_5000);
        chk("R6", "saved_sr", saved_sr, 32'h0000_0002);
        chk("R11", "fault_addr held", fault_addr, 32'h1234_5678);
        chk("R11", "trap_code held", trap_code, 32'h0000_03FC);
        quiet();
    endtask

    task automatic t_prio_all();
        fire(1, 1, 1, 32'h0000_6000, 32'h0, 32'h0002_0000, 8'h01, 32'h0BAD_F00D, 1);
        chk("R9", "event_code all", {20'd0, event_code}, 32'h100);
        chk("R9", "saved_pc all", saved_pc, 32'h0000_6000);
        chk("R9", "fault_addr all", fault_addr, 32'h0BAD_F00D);
        chk("R9", "trap_code all", trap_code, 32'h0000_03FC);
        quiet();
    endtask

    task automatic t_prio_ill_trap();
        fire(1, 0, 1, 32'h0000_7000, 32'h0, 32'h0003_0000, 8'h02, 32'h7777_7777, 0);
        chk("R9", "event_code ill+trap", {20'd0, event_code}, 32'h180);
        chk("R9", "saved_pc ill+trap", saved_pc, 32'h0000_7000);
        chk("R9", "trap_code ill+trap", trap_code, 32'h0000_03FC);
        chk("R9", "fault_addr ill+trap", fault_addr, 32'h0BAD_F00D);
        quiet();
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) quiet();
        chk("R10", "saved_pc", saved_pc, 32'h0000_7000);
        chk("R10", "event_code", {20'd0, event_code}, 32'h180);
        chk("R10", "new_sr", new_sr, 32'h7000_0000);
        chk("R10", "redirect_pc", redirect_pc, 32'h0003_0100);
        chk("R10", "redirect_vld", {31'd0, redirect_vld}, 0);
    endtask

    task automatic t_back_to_back();
        fire(1, 0, 0, 32'h0000_8000, 32'h0, 32'h0004_0000, 8'h04, 32'h0, 0);
        chk("R8", "first redirect", {31'd0, redirect_vld}, 1);
        fire(0, 1, 0, 32'h0000_9000, 32'h0, 32'h0005_0000, 8'h05, 32'h0000_00F0, 0);
        chk("R8", "chained redirect", {31'd0, redirect_vld}, 1);
        chk("R8", "chained target", redirect_pc, 32'h0005_0100);
        chk("R5", "chained event_code", {20'd0, event_code}, 32'h0E0);
        chk("R3", "first trap_code kept", trap_code, 32'h0000_0010);
        quiet();
        chk("R8", "chained drop", {31'd0, redirect_vld}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_trap();
        t_trap_max_imm();
        t_addr_read();
        t_addr_write();
        t_illegal();
        t_prio_all();
        t_prio_ill_trap();
        t_hold();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule